// File: doc/BRIEF.md
# Affine Warp Coordinate Generator

This block walks a square pixel block in raster order. For every pixel it returns the position in the reference frame to which a six-coefficient affine global motion model maps it. For each frame the caller supplies six coefficients: two scale/shear terms and one translation per axis. It also supplies the base-2 logarithms of the scaled frame width and height, a model selector, a chroma flag and the block origin, and pulses `start`. The block captures these values and spends one setup cycle forming the block's first coordinate with four multiplications. After that it produces one coordinate per accepted handshake, using only additions.

The horizontal reference coordinate is X' = gx_a*X/2^w_log2 + gx_b*Y/2^h_log2 + gx_t/4. The vertical coordinate is Y' = gy_a*X/2^w_log2 + gy_b*Y/2^h_log2 + gy_t/4. Here (X, Y) is the pixel position in the current frame. Both divisions by powers of two are exact shifts. The accumulators hold FRAC fractional bits, so no rounding error builds up along a scanline. Each output coordinate is an integer part plus a 4-bit fraction. A downstream bilinear interpolator consumes these through a valid/ready handshake, and a `stall` input can freeze the walk at any point.

Top module: `aff_warp_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy` and `out_valid` are low.
- R2: A `start` sampled while idle raises `busy` on the next edge, with `out_valid` still low for that one setup cycle. `out_valid` rises on the following edge unless `stall` is high.
- R3: With `model`=3 (affine), each output carries the coordinate formula above. `ref_*_int` holds bits [FRAC+15:FRAC] of the exact value scaled by 2^FRAC, which is the floor of the coordinate, wrapped to 16 bits. `ref_*_frac` holds the 4 bits directly below the binary point.
- R4: In luma mode (`chroma`=0) the block delivers 256 coordinates. X = blk_x+col and Y = blk_y+row, with the column running fastest. `out_last` is high only on the 256th, and `busy` is low on the edge after it is accepted.
- R5: With `model`=0 (stationary), every output is exactly (X, Y) with zero fraction, and all six coefficients are ignored.
- R6: With `model`=1 (translational), the output is (X + gx_t/4, Y + gy_t/4), and gx_a, gx_b, gy_a and gy_b are ignored.
- R7: With `model`=2 (isotropic), gy_a is replaced by -gx_b and gy_b by gx_a, and the gy_a and gy_b inputs are ignored.
- R8: With `chroma`=1 the block is 8x8 (64 outputs, `out_last` on the 64th), and the translation terms count in eighths instead of quarters.
- R9: While `out_valid` is high and `out_ready` is low, the coordinate outputs hold their value and no coordinate is skipped.
- R10: While `stall` is high, `out_valid` is low and the walk does not advance. Once `stall` falls, the walk resumes with the next coordinate in the sequence.
- R11: A `start` pulse, and any change of the parameter inputs, while `busy` is high has no effect on the coordinates being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture parameters and begin a block (when idle) |
| model | input | 2 | 0 stationary, 1 translational, 2 isotropic, 3 affine |
| chroma | input | 1 | 1 selects an 8x8 block with eighth-pel translation |
| gx_a | input | 16 | Signed X-to-horizontal coefficient |
| gx_b | input | 16 | Signed Y-to-horizontal coefficient |
| gy_a | input | 16 | Signed X-to-vertical coefficient |
| gy_b | input | 16 | Signed Y-to-vertical coefficient |
| gx_t | input | 16 | Signed horizontal translation, quarter-pel |
| gy_t | input | 16 | Signed vertical translation, quarter-pel |
| w_log2 | input | 5 | log2 of scaled width (clamped to FRAC) |
| h_log2 | input | 5 | log2 of scaled height (clamped to FRAC) |
| blk_x | input | 12 | Block origin column |
| blk_y | input | 12 | Block origin row |
| stall | input | 1 | Freeze the walk and hide `out_valid` |
| out_ready | input | 1 | Consumer accepts the current coordinate |
| busy | output | 1 | Block in setup or walk |
| out_valid | output | 1 | Coordinate outputs are valid |
| out_last | output | 1 | Current coordinate is the last of the block |
| ref_x_int | output | 16 | Horizontal integer part (floor) |
| ref_x_frac | output | 4 | Horizontal fraction, sixteenths |
| ref_y_int | output | 16 | Vertical integer part (floor) |
| ref_y_frac | output | 4 | Vertical fraction, sixteenths |

## Verification
The main hazard is the transition from the end of a row to the start of the next. A design that carried on from the last column instead of reloading from the row-start accumulator would drift by a whole row's worth of column steps. The bench compares every coordinate against a direct multiply-and-shift evaluation, so it catches this at the first pixel of row 1, including for negative coefficients, where a non-floor integer split would also show up as a wrong integer part. Irregular backpressure and stall patterns would expose a design that advanced on valid alone or dropped a coordinate; the same patterns would also expose a design that kept accepting while stalled. Garbage coefficients sent in the unused slots of the simpler models, and a start pulse sent mid-block, would expose a design that leaked those inputs into the output. The chroma runs check both the 64-pixel length and the eighth-pel translation.

// File: rtl/aff_warp_pkg.sv
`timescale 1ns/1ps
package aff_warp_pkg;

    // Warp model selector encoding (matches the model port)
    typedef enum logic [1:0] {
        MDL_STILL  = 2'd0,
        MDL_SHIFT  = 2'd1,
        MDL_ISO    = 2'd2,
        MDL_AFFINE = 2'd3
    } warp_model_e;

    // Walk sequencer states
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SETUP = 2'd1,
        SC_RUN   = 2'd2
    } scan_state_e;

    // Step controls shared by both axis accumulators
    typedef struct packed {
        logic load;
        logic step;
        logic wrap;
    } step_ctl_t;

    // Left shift that turns a coefficient divided by 2^log2v into FRAC-bit fixed point
    function automatic int frac_shift(input int log2v, input int frac);
        return (log2v > frac) ? 0 : (frac - log2v);
    endfunction

endpackage

// File: rtl/aff_param_unit.sv
`timescale 1ns/1ps
module aff_param_unit
    import aff_warp_pkg::*;
#(
    parameter int MW   = 16,
    parameter int TW   = 16,
    parameter int CW   = 12,
    parameter int EW   = 5,
    parameter int FRAC = 16,
    parameter int AW   = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic [1:0]           model,
    input  logic                 chroma,
    input  logic signed [MW-1:0] gx_a,
    input  logic signed [MW-1:0] gx_b,
    input  logic signed [MW-1:0] gy_a,
    input  logic signed [MW-1:0] gy_b,
    input  logic signed [TW-1:0] gx_t,
    input  logic signed [TW-1:0] gy_t,
    input  logic [EW-1:0]        w_log2,
    input  logic [EW-1:0]        h_log2,
    input  logic [CW-1:0]        blk_x,
    input  logic [CW-1:0]        blk_y,
    output logic signed [AW-1:0] x_col_inc,
    output logic signed [AW-1:0] x_row_inc,
    output logic signed [AW-1:0] y_col_inc,
    output logic signed [AW-1:0] y_row_inc,
    output logic signed [AW-1:0] x_start,
    output logic signed [AW-1:0] y_start
);

    // One pixel in accumulator units
    localparam logic signed [AW-1:0] UNIT = {{(AW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

    logic signed [AW-1:0] xa_e, xb_e, ya_e, yb_e, xt_e, yt_e;
    logic signed [AW-1:0] xc_d, xr_d, yc_d, yr_d, tx_d, ty_d;
    logic signed [AW-1:0] xc_q, xr_q, yc_q, yr_q, tx_q, ty_q;
    logic signed [AW-1:0] ox_q, oy_q;
    int sh_w, sh_h, sh_t;

    assign xa_e = AW'(gx_a);
    assign xb_e = AW'(gx_b);
    assign ya_e = AW'(gy_a);
    assign yb_e = AW'(gy_b);
    assign xt_e = AW'(gx_t);
    assign yt_e = AW'(gy_t);

    // Power-of-two divisions become left shifts into the fixed-point grid
    assign sh_w = frac_shift(int'(w_log2), FRAC);
    assign sh_h = frac_shift(int'(h_log2), FRAC);
    assign sh_t = chroma ? (FRAC - 3) : (FRAC - 2);

    // Fold the model choice into a uniform set of increments
    always_comb begin
        xc_d = UNIT;
        xr_d = '0;
        yc_d = '0;
        yr_d = UNIT;
        tx_d = '0;
        ty_d = '0;
        case (warp_model_e'(model))
            MDL_STILL: begin
            end
            MDL_SHIFT: begin
                tx_d = xt_e <<< sh_t;
                ty_d = yt_e <<< sh_t;
            end
            MDL_ISO: begin
                xc_d = xa_e <<< sh_w;
                xr_d = xb_e <<< sh_h;
                yc_d = (-xb_e) <<< sh_w;
                yr_d = xa_e <<< sh_h;
                tx_d = xt_e <<< sh_t;
                ty_d = yt_e <<< sh_t;
            end
            default: begin
                xc_d = xa_e <<< sh_w;
                xr_d = xb_e <<< sh_h;
                yc_d = ya_e <<< sh_w;
                yr_d = yb_e <<< sh_h;
                tx_d = xt_e <<< sh_t;
                ty_d = yt_e <<< sh_t;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xc_q <= '0;
            xr_q <= '0;
            yc_q <= '0;
            yr_q <= '0;
            tx_q <= '0;
            ty_q <= '0;
            ox_q <= '0;
            oy_q <= '0;
        end else if (capture) begin
            xc_q <= xc_d;
            xr_q <= xr_d;
            yc_q <= yc_d;
            yr_q <= yr_d;
            tx_q <= tx_d;
            ty_q <= ty_d;
            ox_q <= AW'(blk_x);
            oy_q <= AW'(blk_y);
        end
    end

    // The only multiplications of a block: origin times the four step terms
    assign x_start = ox_q * xc_q + oy_q * xr_q + tx_q;
    assign y_start = ox_q * yc_q + oy_q * yr_q + ty_q;

    assign x_col_inc = xc_q;
    assign x_row_inc = xr_q;
    assign y_col_inc = yc_q;
    assign y_row_inc = yr_q;

endmodule

// File: rtl/aff_axis_stepper.sv
`timescale 1ns/1ps
module aff_axis_stepper
    import aff_warp_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  step_ctl_t            ctl,
    input  logic signed [AW-1:0] start_val,
    input  logic signed [AW-1:0] col_inc,
    input  logic signed [AW-1:0] row_inc,
    output logic signed [AW-1:0] pos
);

    logic signed [AW-1:0] row_q, col_q, row_next;

    assign row_next = row_q + row_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (ctl.load) begin
            row_q <= start_val;
            col_q <= start_val;
        end else if (ctl.step) begin
            if (ctl.wrap) begin
                row_q <= row_next;
                col_q <= row_next;
            end else begin
                col_q <= col_q + col_inc;
            end
        end
    end

    assign pos = col_q;

endmodule

// File: rtl/aff_scan_ctrl.sv
`timescale 1ns/1ps
module aff_scan_ctrl
    import aff_warp_pkg::*;
#(
    parameter int BLK  = 16,
    parameter int CNTW = $clog2(BLK)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      chroma,
    input  logic      stall,
    input  logic      out_ready,
    output logic      busy,
    output logic      capture,
    output logic      out_valid,
    output logic      out_last,
    output step_ctl_t ctl
);

    scan_state_e     st_q;
    logic            chroma_q;
    logic [CNTW-1:0] col_q, row_q, lim;
    logic            at_col_end, at_row_end, fire;

    assign lim        = chroma_q ? CNTW'(BLK / 2 - 1) : CNTW'(BLK - 1);
    assign at_col_end = (col_q == lim);
    assign at_row_end = (row_q == lim);

    assign busy      = (st_q != SC_IDLE);
    assign capture   = (st_q == SC_IDLE) && start;
    assign out_valid = (st_q == SC_RUN) && !stall;
    assign out_last  = out_valid && at_col_end && at_row_end;
    assign fire      = out_valid && out_ready;

    assign ctl.load = (st_q == SC_SETUP);
    assign ctl.step = fire;
    assign ctl.wrap = fire && at_col_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SC_IDLE;
            chroma_q <= 1'b0;
            col_q    <= '0;
            row_q    <= '0;
        end else begin
            case (st_q)
                SC_IDLE: begin
                    if (start) begin
                        st_q     <= SC_SETUP;
                        chroma_q <= chroma;
                    end
                end
                SC_SETUP: begin
                    st_q  <= SC_RUN;
                    col_q <= '0;
                    row_q <= '0;
                end
                SC_RUN: begin
                    if (fire) begin
                        if (at_col_end) begin
                            col_q <= '0;
                            if (at_row_end) begin
                                st_q <= SC_IDLE;
                            end else begin
                                row_q <= row_q + CNTW'(1);
                            end
                        end else begin
                            col_q <= col_q + CNTW'(1);
                        end
                    end
                end
                default: st_q <= SC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aff_warp_gen.sv
`timescale 1ns/1ps
module aff_warp_gen
    import aff_warp_pkg::*;
#(
    parameter int MW   = 16,
    parameter int TW   = 16,
    parameter int CW   = 12,
    parameter int EW   = 5,
    parameter int FRAC = 16,
    parameter int PW   = 16,
    parameter int OFW  = 4,
    parameter int BLK  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            model,
    input  logic                  chroma,
    input  logic signed [MW-1:0]  gx_a,
    input  logic signed [MW-1:0]  gx_b,
    input  logic signed [MW-1:0]  gy_a,
    input  logic signed [MW-1:0]  gy_b,
    input  logic signed [TW-1:0]  gx_t,
    input  logic signed [TW-1:0]  gy_t,
    input  logic [EW-1:0]         w_log2,
    input  logic [EW-1:0]         h_log2,
    input  logic [CW-1:0]         blk_x,
    input  logic [CW-1:0]         blk_y,
    input  logic                  stall,
    input  logic                  out_ready,
    output logic                  busy,
    output logic                  out_valid,
    output logic                  out_last,
    output logic signed [PW-1:0]  ref_x_int,
    output logic [OFW-1:0]        ref_x_frac,
    output logic signed [PW-1:0]  ref_y_int,
    output logic [OFW-1:0]        ref_y_frac
);

    // Accumulator width: coefficient, origin, fraction and carry headroom
    localparam int AW   = MW + CW + FRAC + 4;
    localparam int NAX  = 2;
    localparam int HIW  = AW - FRAC - PW;
    localparam int LOW  = FRAC - OFW;

    logic      capture;
    step_ctl_t ctl;

    logic signed [AW-1:0] x_col_inc, x_row_inc, y_col_inc, y_row_inc, x_start, y_start;
    logic signed [AW-1:0] ax_start [NAX];
    logic signed [AW-1:0] ax_col   [NAX];
    logic signed [AW-1:0] ax_row   [NAX];
    logic signed [AW-1:0] ax_pos   [NAX];

    aff_scan_ctrl #(.BLK(BLK)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .chroma    (chroma),
        .stall     (stall),
        .out_ready (out_ready),
        .busy      (busy),
        .capture   (capture),
        .out_valid (out_valid),
        .out_last  (out_last),
        .ctl       (ctl)
    );

    aff_param_unit #(
        .MW(MW), .TW(TW), .CW(CW), .EW(EW), .FRAC(FRAC), .AW(AW)
    ) u_param (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .model     (model),
        .chroma    (chroma),
        .gx_a      (gx_a),
        .gx_b      (gx_b),
        .gy_a      (gy_a),
        .gy_b      (gy_b),
        .gx_t      (gx_t),
        .gy_t      (gy_t),
        .w_log2    (w_log2),
        .h_log2    (h_log2),
        .blk_x     (blk_x),
        .blk_y     (blk_y),
        .x_col_inc (x_col_inc),
        .x_row_inc (x_row_inc),
        .y_col_inc (y_col_inc),
        .y_row_inc (y_row_inc),
        .x_start   (x_start),
        .y_start   (y_start)
    );

    assign ax_start[0] = x_start;
    assign ax_start[1] = y_start;
    assign ax_col[0]   = x_col_inc;
    assign ax_col[1]   = y_col_inc;
    assign ax_row[0]   = x_row_inc;
    assign ax_row[1]   = y_row_inc;

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        aff_axis_stepper #(.AW(AW)) u_step (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .start_val (ax_start[g]),
            .col_inc   (ax_col[g]),
            .row_inc   (ax_row[g]),
            .pos       (ax_pos[g])
        );
    end

    // Split fixed point into floor integer and leading fraction bits
    assign ref_x_int  = ax_pos[0][FRAC +: PW];
    assign ref_x_frac = ax_pos[0][FRAC-1 -: OFW];
    assign ref_y_int  = ax_pos[1][FRAC +: PW];
    assign ref_y_frac = ax_pos[1][FRAC-1 -: OFW];

    logic unused_bits;
    assign unused_bits = ^{ax_pos[0][AW-1 -: HIW], ax_pos[0][LOW-1:0],
                           ax_pos[1][AW-1 -: HIW], ax_pos[1][LOW-1:0]};

endmodule

// File: rtl/aff_warp_chk.sv
`timescale 1ns/1ps
module aff_warp_chk #(
    parameter int PW  = 16,
    parameter int OFW = 4,
    parameter int BLK = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           chroma,
    input logic           stall,
    input logic           out_ready,
    input logic           busy,
    input logic           out_valid,
    input logic           out_last,
    input logic [PW-1:0]  ref_x_int,
    input logic [OFW-1:0] ref_x_frac,
    input logic [PW-1:0]  ref_y_int,
    input logic [OFW-1:0] ref_y_frac
);

    logic [15:0] fire_cnt;
    logic        ch_q;
    logic        fire;
    int          blk_len;

    assign fire    = out_valid && out_ready;
    assign blk_len = ch_q ? (BLK / 2) * (BLK / 2) : BLK * BLK;

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_cnt <= '0;
            ch_q     <= 1'b0;
        end else if (start && !busy) begin
            fire_cnt <= '0;
            ch_q     <= chroma;
        end else if (fire) begin
            fire_cnt <= fire_cnt + 16'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !out_valid));

    // R2
    setup_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !out_valid));

    // R2
    valid_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> (out_valid || stall));

    // R9
    hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable({ref_x_int, ref_x_frac, ref_y_int, ref_y_frac}));

    // R10
    stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> !out_valid);

    // R4
    last_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && out_last) |-> (int'(fire_cnt) == blk_len - 1));

    // R4
    idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && out_last) |=> !busy);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(fire && out_last)) |=> busy);

endmodule

bind aff_warp_gen aff_warp_chk #(.PW(PW), .OFW(OFW), .BLK(BLK)) u_warp_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .chroma     (chroma),
    .stall      (stall),
    .out_ready  (out_ready),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .ref_x_int  (ref_x_int),
    .ref_x_frac (ref_x_frac),
    .ref_y_int  (ref_y_int),
    .ref_y_frac (ref_y_frac)
);

// File: tb/test_aff_warp_gen.sv
`timescale 1ns/1ps
module test_aff_warp_gen;

    localparam int F = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  model = 2'd0;
    logic        chroma = 1'b0;
    logic signed [15:0] gx_a = '0, gx_b = '0, gy_a = '0, gy_b = '0, gx_t = '0, gy_t = '0;
    logic [4:0]  w_log2 = '0, h_log2 = '0;
    logic [11:0] blk_x = '0, blk_y = '0;
    logic        stall = 1'b0;
    logic        out_ready = 1'b0;
    logic        busy, out_valid, out_last;
    logic signed [15:0] ref_x_int, ref_y_int;
    logic [3:0]  ref_x_frac, ref_y_frac;

    int checks = 0;
    int errors = 0;

    // Saved copy of the parameters of the block under test
    int e_mdl, e_ch, e_a, e_b, e_c, e_d, e_t, e_u, e_lw, e_lh, e_bx, e_by;

    always #2 clk = ~clk;

    aff_warp_gen i_aff_warp_gen (
        .clk(clk), .rst(rst), .start(start), .model(model), .chroma(chroma),
        .gx_a(gx_a), .gx_b(gx_b), .gy_a(gy_a), .gy_b(gy_b), .gx_t(gx_t), .gy_t(gy_t),
        .w_log2(w_log2), .h_log2(h_log2), .blk_x(blk_x), .blk_y(blk_y),
        .stall(stall), .out_ready(out_ready), .busy(busy), .out_valid(out_valid),
        .out_last(out_last), .ref_x_int(ref_x_int), .ref_x_frac(ref_x_frac),
        .ref_y_int(ref_y_int), .ref_y_frac(ref_y_frac)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] pack_pos(input longint v);
        logic [63:0] raw;
        logic [63:0] ip;
        raw = v;
        ip  = v >>> F;
        return {ip[15:0], raw[F-1 -: 4]};
    endfunction

    // Direct evaluation of the mapping for pixel k of the block
    function automatic logic [19:0] exp_axis(input int axis, input int k);
        int n, xx, yy, ts;
        longint v;
        n  = (e_ch != 0) ? 8 : 16;
        xx = e_bx + k % n;
        yy = e_by + k / n;
        ts = F - 2 - e_ch;
        case (e_mdl)
            0: v = (axis == 0) ? (longint'(xx) <<< F) : (longint'(yy) <<< F);
            1: v = (axis == 0) ? ((longint'(xx) <<< F) + (longint'(e_t) <<< ts))
                               : ((longint'(yy) <<< F) + (longint'(e_u) <<< ts));
            2: v = (axis == 0)
                   ? (((longint'(e_a) * xx) <<< (F - e_lw)) + ((longint'(e_b) * yy) <<< (F - e_lh)) + (longint'(e_t) <<< ts))
                   : (((-longint'(e_b) * xx) <<< (F - e_lw)) + ((longint'(e_a) * yy) <<< (F - e_lh)) + (longint'(e_u) <<< ts));
            default: v = (axis == 0)
                   ? (((longint'(e_a) * xx) <<< (F - e_lw)) + ((longint'(e_b) * yy) <<< (F - e_lh)) + (longint'(e_t) <<< ts))
                   : (((longint'(e_c) * xx) <<< (F - e_lw)) + ((longint'(e_d) * yy) <<< (F - e_lh)) + (longint'(e_u) <<< ts));
        endcase
        return pack_pos(v);
    endfunction

    task automatic set_params(input int mdl, input int ch, input int a, input int b,
                              input int c, input int d, input int t, input int u,
                              input int lw, input int lh, input int bx, input int by);
        e_mdl = mdl; e_ch = ch; e_a = a; e_b = b; e_c = c; e_d = d;
        e_t = t; e_u = u; e_lw = lw; e_lh = lh; e_bx = bx; e_by = by;
        model = 2'(mdl); chroma = ch[0];
        gx_a = 16'(a); gx_b = 16'(b); gy_a = 16'(c); gy_b = 16'(d);
        gx_t = 16'(t); gy_t = 16'(u);
        w_log2 = 5'(lw); h_log2 = 5'(lh);
        blk_x = 12'(bx); blk_y = 12'(by);
    endtask

    // Runs one block; bp/st pick backpressure and stall patterns; inj sends a start mid-block
    task automatic run_block(input string req, input int bp, input int st, input bit inj);
        int n, k, cyc;
        logic [19:0] ex, ey;
        n = (e_ch != 0) ? 64 : 256;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        cyc = 0;
        while (k < n && cyc < 4000) begin
            out_ready = (bp == 0) ? 1'b1 : ((cyc % 3) != 0);
            stall     = (st == 0) ? 1'b0 : ((cyc % 7) == 2 || (cyc % 7) == 3);
            if (inj && cyc == 9) begin
                start = 1'b1; model = 2'd0; chroma = 1'b1;
                gx_a = 16'sd77; gx_b = -16'sd300; gy_a = 16'sd9; gy_b = 16'sd1;
                gx_t = 16'sd40; gy_t = -16'sd40; blk_x = 12'd5; blk_y = 12'd700;
            end else begin
                start = 1'b0;
            end
            #1;
            if (stall) chk(!out_valid, "R10", "valid while stalled", longint'(out_valid), 0);
            if (out_valid && out_ready) begin
                ex = exp_axis(0, k);
                ey = exp_axis(1, k);
                chk({ref_x_int, ref_x_frac} == ex, req, $sformatf("x of pixel %0d", k),
                    longint'({ref_x_int, ref_x_frac}), longint'(ex));
                chk({ref_y_int, ref_y_frac} == ey, req, $sformatf("y of pixel %0d", k),
                    longint'({ref_y_int, ref_y_frac}), longint'(ey));
                chk(out_last == (k == n - 1), "R4", $sformatf("last flag at pixel %0d", k),
                    longint'(out_last), longint'(k == n - 1));
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        stall = 1'b0;
        chk(k == n, req, "coordinates delivered", k, n);
        chk(!busy && !out_valid, "R4", "idle after last", longint'({busy, out_valid}), 0);
        out_ready = 1'b0;
    endtask

    task automatic test_reset();
        #1;
        chk(!busy && !out_valid, "R1", "outputs in reset", longint'({busy, out_valid}), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !out_valid, "R1", "outputs after reset", longint'({busy, out_valid}), 0);
    endtask

    task automatic test_latency();
        logic [19:0] p0;
        int guard;
        set_params(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 100, 200);
        out_ready = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !out_valid, "R2", "setup cycle", longint'({busy, out_valid}), 2);
        @(negedge clk);
        chk(out_valid, "R2", "valid after setup", longint'(out_valid), 1);
        p0 = exp_axis(0, 0);
        chk({ref_x_int, ref_x_frac} == p0, "R5", "first x identity",
            longint'({ref_x_int, ref_x_frac}), longint'(p0));
        repeat (3) @(negedge clk);
        chk({ref_x_int, ref_x_frac} == p0 && out_valid, "R9", "held under backpressure",
            longint'({ref_x_int, ref_x_frac}), longint'(p0));
        out_ready = 1'b1;
        guard = 0;
        while (busy && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        chk(!busy, "R2", "drained", longint'(busy), 0);
    endtask

    task automatic test_affine_pos();
        set_params(3, 0, 1100, 37, -25, 1030, 13, -7, 10, 10, 48, 32);
        run_block("R3", 0, 0, 1'b0);
    endtask

    task automatic test_affine_neg();
        set_params(3, 0, -900, -211, 333, -1200, -55, 61, 10, 9, 16, 16);
        run_block("R3", 1, 0, 1'b0);
    endtask

    task automatic test_affine_wide();
        set_params(3, 0, 65001 - 65536, 3, -4, 40000 - 65536, 3, 1, 16, 14, 4000, 3000);
        run_block("R3", 0, 0, 1'b0);
    endtask

    task automatic test_stationary();
        set_params(0, 0, 999, -999, 500, -500, 77, -77, 3, 3, 640, 80);
        run_block("R5", 1, 0, 1'b0);
    endtask

    task automatic test_translational();
        set_params(1, 0, 31000, -31000, 1234, -4321, -37, 22, 7, 7, 160, 96);
        run_block("R6", 0, 0, 1'b0);
    endtask

    task automatic test_isotropic();
        set_params(2, 0, 1050, -140, 30000, -30000, 9, -3, 10, 10, 64, 48);
        run_block("R7", 0, 0, 1'b0);
    endtask

    task automatic test_chroma();
        set_params(3, 1, 520, 12, -12, 500, 27, -13, 9, 9, 40, 24);
        run_block("R8", 1, 0, 1'b0);
    endtask

    task automatic test_stall();
        set_params(3, 0, 1020, -44, 44, 1020, 6, 10, 10, 10, 80, 112);
        run_block("R10", 1, 1, 1'b0);
    endtask

    task automatic test_busy_start();
        set_params(3, 0, 700, 150, -150, 700, -20, 20, 9, 9, 208, 144);
        run_block("R11", 0, 0, 1'b1);
    endtask

    initial begin
        test_reset();
        test_latency();
        test_affine_pos();
        test_affine_neg();
        test_affine_wide();
        test_stationary();
        test_translational();
        test_isotropic();
        test_chroma();
        test_stall();
        test_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule